// File: doc/BRIEF.md
# Dual-Issue Instruction Queue Dispatcher

This block sits between an instruction fetcher and four execution units. It keeps a small in-order queue of decoded instructions. Each cycle it takes up to two new instructions from the fetcher and sends up to two instructions from the head of the queue to the reservation stations of their target units: integer, floating-point, load/store or system. The fetcher is told every cycle how many slots are free, and the block never takes more than that.

Before an instruction leaves, the block checks its source and destination registers against a register-busy scoreboard of writes still in flight. It also checks whether two head instructions may travel in the same cycle, and it holds back serializing instructions until the machine is quiet. Dispatch is strictly in order. A flush input drops the whole queue in one cycle.

Each instruction is a 30-bit word, laid out MSB first as: unit [29:28], serializing flag [27], destination valid [26], destination register [25:21], source A valid [20], source A register [19:15], source B valid [14], source B register [13:9], tag [8:0]. The unit codes are 0 integer, 1 floating-point, 2 load/store and 3 system. Unit u owns bit u of `rs_ready`/`rs_valid` and bits [u*30 +: 30] of `rs_data`.

Top module: `iq_dispatch`

## Requirements
- R1: After synchronous reset the queue is empty, `free_slots` is 6 and `rs_valid` is all zero.
- R2: `free_slots` equals 6 minus the number of held instructions, taken from the registered occupancy at the start of the cycle.
- R3: A `fill_count` of 0, 1 or 2 requests that many instructions (slot 0 first), and a value of 3 counts as 2. The number accepted is the smaller of the request and `free_slots`. Instructions that are not accepted are dropped.
- R4: At most two instructions leave per cycle, always from the head and in queue order. Each goes to the unit named in its unit field, with its full word on that unit's `rs_data` slice. If the oldest instruction cannot leave, the second one is held as well.
- R5: An instruction leaves only when `rs_ready` of its unit is 1 in that cycle. `rs_valid` is never 1 for a unit whose `rs_ready` is 0.
- R6: An instruction whose valid source or destination register has its bit set in `reg_busy` is held until that bit clears.
- R7: The two head instructions do not leave together if they name the same unit, or if the younger one reads or writes the older one's valid destination register. In that case only the older one leaves.
- R8: A serializing instruction leaves only as the oldest instruction, only alone, and only when `reg_busy` is all zero. An instruction behind it waits for a later cycle.
- R9: When `flush` is 1 no instruction is sent that cycle, any fill in the same cycle is discarded, and the queue is empty in the next cycle.
- R10: Without a flush, the next occupancy is the old occupancy plus the accepted count minus the sent count. It never goes above 6 or below 0, and an empty queue sends nothing.
- R11: Instructions leave in the order they were written, including after the storage index wraps past the last slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard queue contents and same-cycle fill |
| fill_count | input | 2 | Number of fetched instructions offered this cycle |
| fill_instr0 | input | 30 | Older offered instruction |
| fill_instr1 | input | 30 | Younger offered instruction |
| free_slots | output | 3 | Empty queue slots available to the fetcher |
| rs_ready | input | 4 | Per-unit reservation station can accept |
| reg_busy | input | 32 | Per-register in-flight write flags |
| rs_valid | output | 4 | Per-unit instruction sent this cycle |
| rs_data | output | 120 | Per-unit instruction word |

## Verification
The bench fills the queue with single, paired and over-sized requests until it is full, so wrong clamping or wrong free-slot accounting shows up as lost or extra tags at drain time. Head pairs are tried as independent, same-unit, read-after-write and write-after-write pairs to separate a correct pairing rule from one that is too lax or too strict. A blocked oldest instruction, set busy bits on a source and on a destination, and a serializing instruction with and without an unrelated busy register expose out-of-order leaks and a missing quiet check. Fill while sending, and flush with a fill in the same cycle, test the occupancy arithmetic and the priority of flush over fill.

// File: rtl/iq_pkg.sv
package iq_pkg;

    localparam int REG_W = 5;
    localparam int NREG  = 1 << REG_W;
    localparam int NUNIT = 4;
    localparam int TAG_W = 9;

    typedef enum logic [1:0] {
        U_INT = 2'd0,
        U_FPU = 2'd1,
        U_LSU = 2'd2,
        U_SYS = 2'd3
    } unit_e;

    typedef struct packed {
        unit_e              unit;
        logic               serial;
        logic               dst_v;
        logic [REG_W-1:0]   dst;
        logic               sa_v;
        logic [REG_W-1:0]   sa;
        logic               sb_v;
        logic [REG_W-1:0]   sb;
        logic [TAG_W-1:0]   tag;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);

    // Any named register with an outstanding write blocks the instruction.
    function automatic logic touches_busy(input instr_t i, input logic [NREG-1:0] busy);
        return (i.dst_v && busy[i.dst]) ||
               (i.sa_v  && busy[i.sa])  ||
               (i.sb_v  && busy[i.sb]);
    endfunction

    // The younger of a head pair may not share a cycle with the older one.
    function automatic logic pair_conflict(input instr_t older, input instr_t younger);
        logic dep;
        dep = older.dst_v && ((younger.sa_v  && younger.sa  == older.dst) ||
                              (younger.sb_v  && younger.sb  == older.dst) ||
                              (younger.dst_v && younger.dst == older.dst));
        return dep || (older.unit == younger.unit);
    endfunction

endpackage

// File: rtl/iq_store.sv
module iq_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [1:0]       wr_n,
    input  instr_t           wr0,
    input  instr_t           wr1,
    input  logic [1:0]       rd_n,
    output instr_t           head0,
    output instr_t           head1,
    output logic [CNT_W-1:0] count
);

    instr_t           slots [DEPTH];
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] count_q;
    logic [PTR_W-1:0] tail0;
    logic [PTR_W-1:0] tail1;

    // Circular index advance; the step never exceeds DEPTH.
    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p,
                                             input logic [CNT_W-1:0] k);
        logic [CNT_W:0] s;
        s = (CNT_W+1)'(p) + (CNT_W+1)'(k);
        if (s >= (CNT_W+1)'(DEPTH))
            s = s - (CNT_W+1)'(DEPTH);
        return PTR_W'(s);
    endfunction

    assign tail0 = adv(head_q, count_q);
    assign tail1 = adv(tail0, CNT_W'(1));
    assign head0 = slots[head_q];
    assign head1 = slots[adv(head_q, CNT_W'(1))];
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q  <= '0;
            count_q <= '0;
        end else begin
            head_q  <= adv(head_q, CNT_W'(rd_n));
            count_q <= count_q + CNT_W'(wr_n) - CNT_W'(rd_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush) begin
            if (wr_n != 2'd0)
                slots[tail0] <= wr0;
            if (wr_n == 2'd2)
                slots[tail1] <= wr1;
        end
    end

endmodule

// File: rtl/iq_issue.sv
module iq_issue
    import iq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             flush,
    input  logic [CNT_W-1:0] count,
    input  instr_t           head0,
    input  instr_t           head1,
    input  logic [NUNIT-1:0] rs_ready,
    input  logic [NREG-1:0]  reg_busy,
    output logic             go0,
    output logic             go1,
    output logic [1:0]       rd_n
);

    logic quiet;
    logic ok0;
    logic ok1;

    assign quiet = (reg_busy == '0);

    always_comb begin
        ok0 = !flush && (count >= CNT_W'(1)) &&
              rs_ready[head0.unit] &&
              !touches_busy(head0, reg_busy) &&
              (!head0.serial || quiet);
        ok1 = ok0 && (count >= CNT_W'(2)) &&
              !head0.serial && !head1.serial &&
              rs_ready[head1.unit] &&
              !touches_busy(head1, reg_busy) &&
              !pair_conflict(head0, head1);
    end

    assign go0  = ok0;
    assign go1  = ok1;
    assign rd_n = {1'b0, ok0} + {1'b0, ok1};

endmodule

// File: rtl/iq_route.sv
module iq_route
    import iq_pkg::*;
(
    input  logic                     go0,
    input  logic                     go1,
    input  instr_t                   head0,
    input  instr_t                   head1,
    output logic [NUNIT-1:0]         rs_valid,
    output logic [NUNIT*INSTR_W-1:0] rs_data
);

    for (genvar u = 0; u < NUNIT; u++) begin : g_unit
        logic sel0;
        logic sel1;
        assign sel0 = go0 && (head0.unit == unit_e'(u));
        assign sel1 = go1 && (head1.unit == unit_e'(u));
        assign rs_valid[u] = sel0 || sel1;
        assign rs_data[u*INSTR_W +: INSTR_W] = sel0 ? head0 :
                                               sel1 ? head1 : '0;
    end

endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
    import iq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic [1:0]               fill_count,
    input  logic [INSTR_W-1:0]       fill_instr0,
    input  logic [INSTR_W-1:0]       fill_instr1,
    output logic [CNT_W-1:0]         free_slots,
    input  logic [NUNIT-1:0]         rs_ready,
    input  logic [NREG-1:0]          reg_busy,
    output logic [NUNIT-1:0]         rs_valid,
    output logic [NUNIT*INSTR_W-1:0] rs_data
);

    logic [CNT_W-1:0] count;
    instr_t           head0;
    instr_t           head1;
    logic             go0;
    logic             go1;
    logic [1:0]       rd_n;
    logic [1:0]       req;
    logic [1:0]       acc;

    assign free_slots = CNT_W'(DEPTH) - count;
    assign req        = (fill_count > 2'd2) ? 2'd2 : fill_count;

    always_comb begin
        if (flush)
            acc = 2'd0;
        else if (CNT_W'(req) > free_slots)
            acc = free_slots[1:0];
        else
            acc = req;
    end

    iq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .wr_n  (acc),
        .wr0   (instr_t'(fill_instr0)),
        .wr1   (instr_t'(fill_instr1)),
        .rd_n  (rd_n),
        .head0 (head0),
        .head1 (head1),
        .count (count)
    );

    iq_issue #(.DEPTH(DEPTH)) u_issue (
        .flush    (flush),
        .count    (count),
        .head0    (head0),
        .head1    (head1),
        .rs_ready (rs_ready),
        .reg_busy (reg_busy),
        .go0      (go0),
        .go1      (go1),
        .rd_n     (rd_n)
    );

    iq_route u_route (
        .go0      (go0),
        .go1      (go1),
        .head0    (head0),
        .head1    (head1),
        .rs_valid (rs_valid),
        .rs_data  (rs_data)
    );

endmodule

// File: rtl/iq_dispatch_chk.sv
module iq_dispatch_chk
    import iq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     flush,
    input logic [1:0]               fill_count,
    input logic [CNT_W-1:0]         free_slots,
    input logic [NUNIT-1:0]         rs_ready,
    input logic [NREG-1:0]          reg_busy,
    input logic [NUNIT-1:0]         rs_valid,
    input logic [NUNIT*INSTR_W-1:0] rs_data
);

    int     taken;
    int     sent;
    logic   serial_hit;
    logic   hazard_hit;
    instr_t word;

    always_comb begin
        taken = (fill_count > 2'd2) ? 2 : int'(fill_count);
        if (taken > int'(free_slots))
            taken = int'(free_slots);
        sent       = $countones(rs_valid);
        serial_hit = 1'b0;
        hazard_hit = 1'b0;
        word       = '0;
        for (int u = 0; u < NUNIT; u++) begin
            if (rs_valid[u]) begin
                word = instr_t'(rs_data[u*INSTR_W +: INSTR_W]);
                if (word.serial)
                    serial_hit = 1'b1;
                if ((word.dst_v && reg_busy[word.dst]) ||
                    (word.sa_v && reg_busy[word.sa]) ||
                    (word.sb_v && reg_busy[word.sb]))
                    hazard_hit = 1'b1;
            end
        end
    end

    AST_FREE_BOUND:  assert property (@(posedge clk) disable iff (rst) free_slots <= CNT_W'(DEPTH)); // R10
    AST_READY_GATE:  assert property (@(posedge clk) disable iff (rst) (rs_valid & ~rs_ready) == '0); // R5
    AST_TWO_MAX:     assert property (@(posedge clk) disable iff (rst) $countones(rs_valid) <= 2); // R4
    AST_EMPTY_IDLE:  assert property (@(posedge clk) disable iff (rst) free_slots == CNT_W'(DEPTH) |-> rs_valid == '0); // R10
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst) flush |-> rs_valid == '0); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst) flush |=> free_slots == CNT_W'(DEPTH)); // R9
    AST_COUNT_STEP:  assert property (@(posedge clk) disable iff (rst)
                         !flush |=> int'(free_slots) == int'($past(free_slots)) - $past(taken) + $past(sent)); // R10
    AST_SERIAL_SOLO: assert property (@(posedge clk) disable iff (rst)
                         serial_hit |-> ($countones(rs_valid) == 1) && (reg_busy == '0)); // R8
    AST_NO_HAZARD:   assert property (@(posedge clk) disable iff (rst) !hazard_hit); // R6

endmodule

bind iq_dispatch iq_dispatch_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .fill_count (fill_count),
    .free_slots (free_slots),
    .rs_ready   (rs_ready),
    .reg_busy   (reg_busy),
    .rs_valid   (rs_valid),
    .rs_data    (rs_data)
);

// File: tb/iq_dispatch_tb.sv
module iq_dispatch_tb;
    import iq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;
    localparam int W          = INSTR_W;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 flush = 1'b0;
    logic [1:0]           fill_count = 2'd0;
    logic [W-1:0]         fill_instr0 = '0;
    logic [W-1:0]         fill_instr1 = '0;
    logic [2:0]           free_slots;
    logic [NUNIT-1:0]     rs_ready = '0;
    logic [NREG-1:0]      reg_busy = '0;
    logic [NUNIT-1:0]     rs_valid;
    logic [NUNIT*W-1:0]   rs_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_dispatch #(.DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush),
        .fill_count  (fill_count),
        .fill_instr0 (fill_instr0),
        .fill_instr1 (fill_instr1),
        .free_slots  (free_slots),
        .rs_ready    (rs_ready),
        .reg_busy    (reg_busy),
        .rs_valid    (rs_valid),
        .rs_data     (rs_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic instr_t mk(input unit_e u, input logic ser,
                                  input logic dv, input int d,
                                  input logic av, input int a,
                                  input logic bv, input int b, input int tag);
        instr_t t;
        t.unit   = u;
        t.serial = ser;
        t.dst_v  = dv;
        t.dst    = REG_W'(d);
        t.sa_v   = av;
        t.sa     = REG_W'(a);
        t.sb_v   = bv;
        t.sb     = REG_W'(b);
        t.tag    = TAG_W'(tag);
        return t;
    endfunction

    function automatic int tag_of(input int u);
        instr_t t;
        t = instr_t'(rs_data[u*W +: W]);
        return int'(t.tag);
    endfunction

    function automatic instr_t plain(input unit_e u, input int tag);
        return mk(u, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0, tag);
    endfunction

    // Offer n instructions for one cycle; returns just after the next falling edge.
    task automatic push(input int n, input instr_t a, input instr_t b);
        fill_count  = 2'(n);
        fill_instr0 = a;
        fill_instr1 = b;
        @(negedge clk);
        fill_count = 2'd0;
        #1;
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 free after reset", int'(free_slots), 6);
        chk("R1 no send after reset", int'(rs_valid), 0);
    endtask

    task automatic t_fill_limits();
        rs_ready = 4'b0000;
        push(2, plain(U_INT, 1), plain(U_INT, 2));
        chk("R2 free after two", int'(free_slots), 4);
        push(3, plain(U_INT, 3), plain(U_INT, 4));
        chk("R3 count 3 taken as 2", int'(free_slots), 2);
        push(1, plain(U_INT, 5), plain(U_INT, 99));
        chk("R3 single fill", int'(free_slots), 1);
        push(2, plain(U_INT, 6), plain(U_INT, 7));
        chk("R3 clipped to free space", int'(free_slots), 0);
        push(2, plain(U_INT, 8), plain(U_INT, 9));
        chk("R3 full queue refuses", int'(free_slots), 0);
        chk("R5 no send without ready", int'(rs_valid), 0);
        rs_ready = 4'b1111;
        #1;
        for (int k = 1; k <= 6; k++) begin
            chk("R7 same unit sends one", int'(rs_valid), 1);
            chk("R11 order of drain", tag_of(0), k);
            step();
        end
        chk("R10 empty after drain", int'(free_slots), 6);
        chk("R10 empty sends nothing", int'(rs_valid), 0);
    endtask

    task automatic t_pair();
        rs_ready = 4'b1111;
        push(2, plain(U_INT, 10), plain(U_FPU, 11));
        chk("R4 pair sent", int'(rs_valid), 3);
        chk("R4 older word on int", tag_of(0), 10);
        chk("R4 younger word on fpu", tag_of(1), 11);
        step();
        chk("R10 pair drained", int'(free_slots), 6);
    endtask

    task automatic t_stream();
        rs_ready = 4'b1111;
        fill_count  = 2'd2;
        fill_instr0 = plain(U_INT, 20);
        fill_instr1 = plain(U_INT, 21);
        @(negedge clk);
        fill_instr0 = plain(U_INT, 22);
        fill_instr1 = plain(U_INT, 23);
        #1;
        chk("R4 head sends while filling", tag_of(0), 20);
        @(negedge clk);
        fill_count = 2'd0;
        #1;
        chk("R10 fill plus send", int'(free_slots), 3);
        for (int k = 21; k <= 23; k++) begin
            chk("R11 wrapped order", tag_of(0), k);
            step();
        end
        chk("R10 stream drained", int'(free_slots), 6);
    endtask

    task automatic t_dep();
        rs_ready = 4'b1111;
        push(2, mk(U_INT, 1'b0, 1'b1, 5, 1'b0, 0, 1'b0, 0, 30),
                mk(U_LSU, 1'b0, 1'b0, 0, 1'b1, 5, 1'b0, 0, 31));
        chk("R7 read after write splits", int'(rs_valid), 1);
        step();
        chk("R7 dependent follows", int'(rs_valid), 4);
        chk("R7 dependent word", tag_of(2), 31);
        step();
        push(2, mk(U_INT, 1'b0, 1'b1, 8, 1'b0, 0, 1'b0, 0, 32),
                mk(U_FPU, 1'b0, 1'b1, 8, 1'b0, 0, 1'b0, 0, 33));
        chk("R7 write after write splits", int'(rs_valid), 1);
        step();
        chk("R7 second writer follows", int'(rs_valid), 2);
        step();
        push(2, mk(U_INT, 1'b0, 1'b1, 5, 1'b0, 0, 1'b0, 0, 34),
                mk(U_LSU, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 6, 35));
        chk("R7 unrelated registers pair", int'(rs_valid), 5);
        step();
    endtask

    task automatic t_in_order();
        rs_ready = 4'b1110;
        push(2, plain(U_INT, 40), plain(U_FPU, 41));
        chk("R4 blocked head holds younger", int'(rs_valid), 0);
        rs_ready = 4'b1111;
        #1;
        chk("R4 pair after release", int'(rs_valid), 3);
        step();
    endtask

    task automatic t_busy();
        rs_ready = 4'b1111;
        reg_busy = 32'h0000_0080;
        push(1, mk(U_LSU, 1'b0, 1'b0, 0, 1'b1, 7, 1'b0, 0, 50), plain(U_INT, 0));
        chk("R6 busy source holds", int'(rs_valid), 0);
        reg_busy = '0;
        #1;
        chk("R6 source freed", int'(rs_valid), 4);
        step();
        reg_busy = 32'h0000_0200;
        push(1, mk(U_INT, 1'b0, 1'b1, 9, 1'b0, 0, 1'b0, 0, 51), plain(U_INT, 0));
        chk("R6 busy destination holds", int'(rs_valid), 0);
        reg_busy = '0;
        #1;
        chk("R6 destination freed", int'(rs_valid), 1);
        step();
    endtask

    task automatic t_serial();
        rs_ready = 4'b1111;
        push(2, plain(U_INT, 60), mk(U_SYS, 1'b1, 1'b0, 0, 1'b0, 0, 1'b0, 0, 61));
        chk("R8 serializing not paired", int'(rs_valid), 1);
        reg_busy = 32'h0000_0008;
        push(1, plain(U_FPU, 62), plain(U_INT, 0));
        chk("R8 waits for quiet scoreboard", int'(rs_valid), 0);
        reg_busy = '0;
        #1;
        chk("R8 sent alone", int'(rs_valid), 8);
        chk("R8 serializing word", tag_of(3), 61);
        step();
        chk("R8 follower later", int'(rs_valid), 2);
        step();
    endtask

    task automatic t_flush();
        rs_ready = 4'b0000;
        push(2, plain(U_INT, 70), plain(U_FPU, 71));
        rs_ready    = 4'b1111;
        flush       = 1'b1;
        fill_count  = 2'd2;
        fill_instr0 = plain(U_INT, 72);
        fill_instr1 = plain(U_LSU, 73);
        #1;
        chk("R9 nothing sent in flush", int'(rs_valid), 0);
        @(negedge clk);
        flush      = 1'b0;
        fill_count = 2'd0;
        #1;
        chk("R9 empty after flush", int'(free_slots), 6);
        chk("R9 fill dropped", int'(rs_valid), 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_fill_limits();
        t_pair();
        t_stream();
        t_dep();
        t_in_order();
        t_busy();
        t_serial();
        t_flush();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule